// File: doc/BRIEF.md
# Logic Self-Test Pattern and Signature Engine

This block runs a complete logic self-test session over a group of parallel scan chains. A start pulse loads the session settings. The block then runs a fixed sequence of patterns. In each pattern, the chains are filled with pseudorandom stimulus from an on-chip 32-bit Galois LFSR while scan enable is high. A single capture pulse follows. While the next pattern shifts in, the responses of the previous pattern shift out, and every shift cycle folds them into a 32-bit multiple-input signature register. After the last capture, one more shift pass unloads the final responses. The block then compares the signature with the expected value it was given, raises done, and reports pass or fail.

Every bit that reaches the signature register must be a known value. For that reason, whole chains can be excluded by a mask vector. A mode bit chooses whether a masked chain is blocked only where it enters the compactor, or is also fed a constant zero during shift. A low-power weight limits how often each chain input may change during shift. All session settings are captured at start, so the inputs may change freely while a session runs.

Top module: `lbist_engine`

## Requirements
- R1: After reset, and in the cycle after a start pulse, signature is 0 and done and pass are 0. Start reloads the generator seed (parameter SEED, default 32'h1D87_2B41).
- R2: Generator step: next = (s >> 1) ^ (s[0] ? 32'h8020_0003 : 0). Each scan-in vector comes from the current generator state, and the generator then takes one step. Chain i's fresh bit is state bit i. The first vector of a session comes from SEED itself, with a previous vector of 0.
- R3: A session of N patterns is N+1 passes of SHIFT_LEN cycles each, with scan_en high and capture low. A single cycle with capture high and scan_en low separates consecutive passes, giving N capture cycles in total.
- R4: On every shift cycle, and only then: signature_next = (sig << 1) ^ (sig[31] ? 32'h0040_0007 : 0) ^ (zero-extended masked scan_out in bits NCHAIN-1:0).
- R5: A chain whose chain_mask bit is 1 always contributes 0 to the signature, whatever its scan_out value.
- R6: With mask_in_en = 1, every masked chain's scan_in is 0 during shift. With mask_in_en = 0, masked chains still receive generator stimulus.
- R7: When lp_weight = 0, every chain takes its fresh bit. Otherwise chain i takes its fresh bit only when generator state bits [NCHAIN+3i+2 : NCHAIN+3i] < lp_weight, and otherwise repeats its previous scan-in bit.
- R8: At the end of the final unload pass, done rises and pass = (signature == expected). Both hold, with scan_en and capture low, until the next start.
- R9: A start pulse, including one in the middle of a session, clears done and pass and begins a fresh session.
- R10: The pattern counter is CNT_W bits wide (default 18). A count of 0 gives a single unload pass with no capture.
- R11: Changes to pat_count, exp_sig, chain_mask, mask_in_en and lp_weight after the start pulse have no effect on the running session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Session start pulse |
| pat_count | input | CNT_W | Number of capture patterns |
| exp_sig | input | 32 | Expected final signature |
| chain_mask | input | NCHAIN | Per-chain mask, 1 = masked |
| mask_in_en | input | 1 | 1 = also block masked chain inputs |
| lp_weight | input | 3 | Low-power toggle weight, 0 = off |
| scan_out | input | NCHAIN | Chain response bits |
| scan_in | output | NCHAIN | Chain stimulus bits |
| scan_en | output | 1 | High during shift cycles |
| capture | output | 1 | Capture pulse |
| signature | output | 32 | Current signature register |
| done | output | 1 | Session finished |
| pass | output | 1 | Final signature matched |

## Verification
A wrong generator state shows up as a mismatch on scan_in in the very next shift cycle. The bench therefore compares scan_in against its model on every shift cycle, and a fault there is flagged within one clock. A fault in the compactor, or a mask leak, changes the signature output in the cycle after the offending shift. It also turns pass false at the end of the session. A sequencing fault shows up as scan_en or capture high in the wrong cycle, counted from the start pulse.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    localparam int unsigned SIG_W = 32;
    localparam logic [SIG_W-1:0] PRPG_TAPS = 32'h8020_0003;
    localparam logic [SIG_W-1:0] MISR_TAPS = 32'h0040_0007;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_CAPT  = 2'd2
    } lbist_state_e;

    function automatic logic [SIG_W-1:0] prpg_step(input logic [SIG_W-1:0] s);
        return (s >> 1) ^ (s[0] ? PRPG_TAPS : '0);
    endfunction

endpackage

// File: rtl/lbist_stim_gen.sv
module lbist_stim_gen
    import lbist_pkg::*;
#(
    parameter int unsigned NCHAIN = 8,
    parameter int unsigned WT_W   = 3
) (
    input  logic [SIG_W-1:0]  lfsr_cur,
    input  logic [NCHAIN-1:0] si_prev,
    input  logic [NCHAIN-1:0] mask,
    input  logic              in_block,
    input  logic [WT_W-1:0]   weight,
    output logic [NCHAIN-1:0] si_next,
    output logic [SIG_W-1:0]  lfsr_next
);

    // Each chain uses one fresh bit plus WT_W spare bits of the generator.
    localparam int unsigned BITS_USED = NCHAIN * (WT_W + 1);

    if (BITS_USED > SIG_W) begin : g_bad_cfg
        initial $error("lbist_stim_gen: NCHAIN too large for generator width");
    end

    assign lfsr_next = prpg_step(lfsr_cur);

    for (genvar g = 0; g < NCHAIN; g++) begin : g_chain
        logic [WT_W-1:0] spare;
        logic            allow;
        assign spare = lfsr_cur[NCHAIN + WT_W*g +: WT_W];
        assign allow = (weight == '0) || (spare < weight);
        always_comb begin
            if (in_block && mask[g]) begin
                si_next[g] = 1'b0;
            end else if (allow) begin
                si_next[g] = lfsr_cur[g];
            end else begin
                si_next[g] = si_prev[g];
            end
        end
    end

endmodule

// File: rtl/lbist_compactor.sv
module lbist_compactor
    import lbist_pkg::*;
#(
    parameter int unsigned NCHAIN = 8
) (
    input  logic [SIG_W-1:0]  sig_cur,
    input  logic [NCHAIN-1:0] resp,
    input  logic [NCHAIN-1:0] mask,
    output logic [SIG_W-1:0]  sig_next
);

    localparam int unsigned PAD_W = SIG_W - NCHAIN;

    logic [SIG_W-1:0] feedback;
    logic [SIG_W-1:0] folded;

    assign feedback = sig_cur[SIG_W-1] ? MISR_TAPS : '0;
    assign folded   = {{PAD_W{1'b0}}, resp & ~mask};
    assign sig_next = {sig_cur[SIG_W-2:0], 1'b0} ^ feedback ^ folded;

endmodule

// File: rtl/lbist_engine.sv
module lbist_engine
    import lbist_pkg::*;
#(
    parameter int unsigned NCHAIN    = 8,
    parameter int unsigned SHIFT_LEN = 16,
    parameter int unsigned CNT_W     = 18,
    parameter logic [31:0] SEED      = 32'h1D87_2B41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  pat_count,
    input  logic [31:0]       exp_sig,
    input  logic [NCHAIN-1:0] chain_mask,
    input  logic              mask_in_en,
    input  logic [2:0]        lp_weight,
    input  logic [NCHAIN-1:0] scan_out,
    output logic [NCHAIN-1:0] scan_in,
    output logic              scan_en,
    output logic              capture,
    output logic [31:0]       signature,
    output logic              done,
    output logic              pass
);

    localparam int unsigned WT_W = 3;
    localparam int unsigned SH_W = (SHIFT_LEN > 1) ? $clog2(SHIFT_LEN) : 1;
    localparam logic [SH_W-1:0] SH_LAST = SH_W'(SHIFT_LEN - 1);

    typedef struct packed {
        lbist_state_e      st;
        logic [SH_W-1:0]   sh;
        logic [CNT_W-1:0]  pat;
        logic [CNT_W-1:0]  npat;
        logic [SIG_W-1:0]  expv;
        logic [NCHAIN-1:0] mask;
        logic              in_block;
        logic [WT_W-1:0]   wt;
        logic [SIG_W-1:0]  lfsr;
        logic [SIG_W-1:0]  misr;
        logic [NCHAIN-1:0] si;
        logic              done;
        logic              pass;
    } regs_t;

    regs_t r_d, r_q;

    // Generator inputs: seed and raw settings on start, session state otherwise.
    logic [SIG_W-1:0]  gen_lfsr_in;
    logic [NCHAIN-1:0] gen_prev_in;
    logic [NCHAIN-1:0] gen_mask_in;
    logic              gen_block_in;
    logic [WT_W-1:0]   gen_wt_in;
    logic [NCHAIN-1:0] gen_si_next;
    logic [SIG_W-1:0]  gen_lfsr_next;
    logic [SIG_W-1:0]  misr_next;

    assign gen_lfsr_in  = start ? SEED        : r_q.lfsr;
    assign gen_prev_in  = start ? '0          : r_q.si;
    assign gen_mask_in  = start ? chain_mask  : r_q.mask;
    assign gen_block_in = start ? mask_in_en  : r_q.in_block;
    assign gen_wt_in    = start ? lp_weight   : r_q.wt;

    lbist_stim_gen #(
        .NCHAIN (NCHAIN),
        .WT_W   (WT_W)
    ) u_stim (
        .lfsr_cur  (gen_lfsr_in),
        .si_prev   (gen_prev_in),
        .mask      (gen_mask_in),
        .in_block  (gen_block_in),
        .weight    (gen_wt_in),
        .si_next   (gen_si_next),
        .lfsr_next (gen_lfsr_next)
    );

    lbist_compactor #(
        .NCHAIN (NCHAIN)
    ) u_misr (
        .sig_cur  (r_q.misr),
        .resp     (scan_out),
        .mask     (r_q.mask),
        .sig_next (misr_next)
    );

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.st       = ST_SHIFT;
            r_d.sh       = '0;
            r_d.pat      = '0;
            r_d.npat     = pat_count;
            r_d.expv     = exp_sig;
            r_d.mask     = chain_mask;
            r_d.in_block = mask_in_en;
            r_d.wt       = lp_weight;
            r_d.lfsr     = gen_lfsr_next;
            r_d.si       = gen_si_next;
            r_d.misr     = '0;
            r_d.done     = 1'b0;
            r_d.pass     = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_SHIFT: begin
                    r_d.misr = misr_next;
                    r_d.lfsr = gen_lfsr_next;
                    r_d.si   = gen_si_next;
                    if (r_q.sh == SH_LAST) begin
                        r_d.sh = '0;
                        if (r_q.pat == r_q.npat) begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                            r_d.pass = (misr_next == r_q.expv);
                        end else begin
                            r_d.st = ST_CAPT;
                        end
                    end else begin
                        r_d.sh = r_q.sh + 1'b1;
                    end
                end
                ST_CAPT: begin
                    r_d.pat = r_q.pat + 1'b1;
                    r_d.st  = ST_SHIFT;
                end
                default: begin
                    r_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.lfsr     <= SEED;
        end else begin
            r_q <= r_d;
        end
    end

    // Latched settings, brought out as named signals for the checker.
    logic [NCHAIN-1:0] cfg_mask_q;
    logic              cfg_block_q;
    assign cfg_mask_q  = r_q.mask;
    assign cfg_block_q = r_q.in_block;

    assign scan_in   = r_q.si;
    assign scan_en   = (r_q.st == ST_SHIFT);
    assign capture   = (r_q.st == ST_CAPT);
    assign signature = r_q.misr;
    assign done      = r_q.done;
    assign pass      = r_q.pass;

endmodule

// File: rtl/lbist_engine_chk.sv
module lbist_engine_chk #(
    parameter int unsigned NCHAIN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              scan_en,
    input logic              capture,
    input logic              done,
    input logic              pass,
    input logic [31:0]       signature,
    input logic [NCHAIN-1:0] scan_in,
    input logic [NCHAIN-1:0] mask_q,
    input logic              block_q
);

    assert_phase_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_en && capture));

    assert_capture_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture);

    assert_capture_to_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !start) |=> scan_en);

    assert_sig_only_on_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !start) |=> $stable(signature));

    assert_input_block_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && block_q) |-> ((scan_in & mask_q) == '0));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_pass_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scan_en && !capture));

    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !pass && signature == '0));

endmodule

bind lbist_engine lbist_engine_chk #(
    .NCHAIN (NCHAIN)
) u_lbist_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .scan_en   (scan_en),
    .capture   (capture),
    .done      (done),
    .pass      (pass),
    .signature (signature),
    .scan_in   (scan_in),
    .mask_q    (cfg_mask_q),
    .block_q   (cfg_block_q)
);

// File: tb/test_lbist_engine.sv
module test_lbist_engine;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 8;
    localparam int SLEN = 16;
    localparam int CW   = 18;
    localparam logic [31:0] SEED = 32'h1D87_2B41;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [CW-1:0]   pat_count = '0;
    logic [31:0]     exp_sig = '0;
    logic [NCH-1:0]  chain_mask = '0;
    logic            mask_in_en = 1'b0;
    logic [2:0]      lp_weight = '0;
    logic [NCH-1:0]  scan_out = '0;
    logic [NCH-1:0]  scan_in;
    logic            scan_en;
    logic            capture;
    logic [31:0]     signature;
    logic            done;
    logic            pass;

    lbist_engine #(
        .NCHAIN    (NCH),
        .SHIFT_LEN (SLEN),
        .CNT_W     (CW),
        .SEED      (SEED)
    ) i_lbist_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .pat_count  (pat_count),
        .exp_sig    (exp_sig),
        .chain_mask (chain_mask),
        .mask_in_en (mask_in_en),
        .lp_weight  (lp_weight),
        .scan_out   (scan_out),
        .scan_in    (scan_in),
        .scan_en    (scan_en),
        .capture    (capture),
        .signature  (signature),
        .done       (done),
        .pass       (pass)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] m_prpg(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
    endfunction

    function automatic logic [31:0] m_misr(input logic [31:0] s, input logic [NCH-1:0] d);
        return {s[30:0], 1'b0} ^ (s[31] ? 32'h0040_0007 : 32'h0) ^ {24'h0, d};
    endfunction

    function automatic logic [NCH-1:0] m_gen(input logic [31:0] l, input logic [NCH-1:0] prev,
                                             input logic [NCH-1:0] mask, input logic blk,
                                             input logic [2:0] wt);
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++) begin
            logic [2:0] sp;
            sp = l[NCH + 3*i +: 3];
            if (blk && mask[i]) v[i] = 1'b0;
            else if (wt == 3'd0 || sp < wt) v[i] = l[i];
            else v[i] = prev[i];
        end
        return v;
    endfunction

    function automatic logic [31:0] xs(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    task automatic run_session(input logic [31:0] rseed, input int npat, input logic [NCH-1:0] mask,
                               input logic blk, input logic [2:0] wt, input bit wrong, input bit midchg);
        logic [31:0]    l, m, r, expv;
        logic [NCH-1:0] si;
        string          si_tag, sig_tag;
        // dry run of the model to get the expected signature
        l = SEED; si = m_gen(l, '0, mask, blk, wt); l = m_prpg(l); m = '0; r = rseed;
        for (int p = 0; p <= npat; p++) begin
            for (int s = 0; s < SLEN; s++) begin
                r  = xs(r);
                m  = m_misr(m, r[NCH-1:0] & ~mask);
                si = m_gen(l, si, mask, blk, wt);
                l  = m_prpg(l);
            end
        end
        expv = wrong ? (m ^ 32'h1) : m;
        si_tag  = (blk && mask != '0) ? "R6 scan_in" : ((wt != 0) ? "R7 scan_in" : "R2 scan_in");
        sig_tag = midchg ? "R11 signature" : ((mask != '0) ? "R5 signature" : "R4 signature");

        start = 1'b1; pat_count = CW'(npat); exp_sig = expv;
        chain_mask = mask; mask_in_en = blk; lp_weight = wt;
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b0 && pass === 1'b0, "R9 done/pass cleared", {done, pass}, 0);
        chk(signature === 32'h0, "R1 signature cleared", signature, 0);

        l = SEED; si = m_gen(l, '0, mask, blk, wt); l = m_prpg(l); m = '0; r = rseed;
        for (int p = 0; p <= npat; p++) begin
            for (int s = 0; s < SLEN; s++) begin
                chk(scan_en === 1'b1 && capture === 1'b0, "R3 shift phase", {scan_en, capture}, 2);
                chk(scan_in === si, si_tag, scan_in, si);
                r = xs(r);
                scan_out = r[NCH-1:0];
                if (midchg) begin
                    chain_mask = NCH'($urandom); mask_in_en = 1'($urandom);
                    lp_weight = 3'($urandom); pat_count = CW'($urandom); exp_sig = $urandom;
                end
                m  = m_misr(m, r[NCH-1:0] & ~mask);
                si = m_gen(l, si, mask, blk, wt);
                l  = m_prpg(l);
                @(negedge clk);
            end
            if (p < npat) begin
                chk(capture === 1'b1 && scan_en === 1'b0, "R3 capture cycle", {scan_en, capture}, 1);
                scan_out = NCH'($urandom);
                @(negedge clk);
            end
        end
        chk(done === 1'b1, "R8 done raised", done, 1);
        chk(pass === !wrong, "R8 pass verdict", pass, !wrong);
        chk(signature === m, sig_tag, signature, m);
        if (npat == 0) chk(done === 1'b1 && signature === m, "R10 zero-count session", signature, m);
        repeat (3) @(negedge clk);
        chk(done === 1'b1 && pass === !wrong && scan_en === 1'b0 && capture === 1'b0,
            "R8 result held", {done, pass, scan_en, capture}, {1'b1, !wrong, 2'b00});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL R3 watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scan_en === 1'b0 && capture === 1'b0, "R1 reset phase", {scan_en, capture}, 0);
        chk(done === 1'b0 && pass === 1'b0 && signature === 32'h0, "R1 reset result",
            {done, pass, signature}, 0);

        run_session(32'h1234_5678, 3, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0);
        run_session(32'h0BAD_F00D, 0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0);
        run_session(32'h5555_0001, 4, 8'hA5, 1'b0, 3'd0, 1'b0, 1'b0);
        run_session(32'h7777_1111, 4, 8'h3C, 1'b1, 3'd0, 1'b0, 1'b0);
        run_session(32'h2468_ACE0, 3, 8'h00, 1'b0, 3'd1, 1'b0, 1'b0);
        run_session(32'h1357_9BDF, 3, 8'h81, 1'b1, 3'd7, 1'b0, 1'b0);
        run_session(32'hDEAD_BEEF, 2, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0);
        run_session(32'hCAFE_0123, 3, 8'h0F, 1'b1, 3'd3, 1'b0, 1'b1);

        // restart in the middle of a running session
        start = 1'b1; pat_count = CW'(5); chain_mask = 8'hFF; mask_in_en = 1'b1; lp_weight = 3'd2;
        @(negedge clk);
        start = 1'b0;
        repeat (7) begin
            scan_out = NCH'($urandom);
            @(negedge clk);
        end
        run_session(32'h0F0F_3C3C, 2, 8'h10, 1'b0, 3'd4, 1'b0, 1'b0);

        for (int k = 0; k < 6; k++) begin
            logic [31:0] rs;
            rs = $urandom | 32'h1;
            run_session(rs, int'($urandom_range(0, 6)), NCH'($urandom), 1'($urandom),
                        3'($urandom), bit'($urandom_range(0, 3) == 0), 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule